// File: doc/BRIEF.md
# IGMP Snooping Frame Classifier

This block watches the header bytes of Ethernet frames as they stream past, one byte per accepted cycle, and decides whether each frame carries an IGMP message. A frame qualifies when it is IPv4, framed either as a plain Ethernet II frame or as an IEEE 802.3 LLC/SNAP frame that carries IP. Its IP version nibble must be 4 and its IP protocol number must be 2. A single 802.1Q VLAN tag ahead of the type or length field is allowed; it moves every later offset by four bytes.

Each frame yields exactly one verdict pulse. The verdict is given as soon as the outcome is certain: on the first header byte that rules the frame out, on the IP protocol byte, or on the last byte of a frame that ends too early. While the snooping enable is set, a positive verdict is latched until the next frame starts. While it is latched, the forwarding port vector is overridden so that the frame goes to the processor port and to no other port. When the verdict is negative, the vector supplied by the forwarding logic passes through unchanged.

The surrounding switch supplies the byte stream with start and end markers and the normal forwarding vector. It consumes the override vector.

Top module: `igmp_snoop_classifier`

## Requirements
- R1: An untagged frame with type 0x0800 in bytes 12–13 (byte 0 is the first byte, marked by the start flag) is classified as IGMP when the upper nibble of byte 14 is 4 and byte 23 equals 0x02.
- R2: A frame whose bytes 12–13 hold a value of 1500 (0x05DC) or less, followed by bytes AA AA 03 00 00 00 08 00 in bytes 14–21, is treated as IP over SNAP. Its IP header starts at byte 22, and the protocol byte is byte 31.
- R3: When bytes 12–13 are 0x8100, four tag bytes are skipped. The type or length field is then read at bytes 16–17, and every IP offset moves by 4. A second 0x8100 is not accepted.
- R4: A frame with a version nibble other than 4, a protocol number other than 2, or a type above 1500 other than 0x0800 is classified as not IGMP.
- R5: A length field above 1500 that is not 0x0800, or any byte of the SNAP header that differs from the expected sequence, gives a negative verdict.
- R6: A frame whose end flag arrives before its protocol byte is classified as not IGMP. A frame whose last byte is the protocol byte is still classified normally.
- R7: Every frame produces exactly one `verdict_valid` pulse, one cycle after the byte that decides it. Bytes accepted outside a frame (after an end flag and before the next start flag) produce no verdict.
- R8: The enable is sampled with the deciding byte. If it is low then, `is_igmp` stays 0. Changing the enable later does not alter a latched verdict.
- R9: While `is_igmp` is 1, `port_vec_out` is one-hot on the processor port (bit 4 by default). Otherwise it equals `port_vec_in`.
- R10: `is_igmp` holds its value until the cycle after the next start-of-frame byte is accepted, and it is 0 from then on until that frame is decided.
- R11: After reset, `verdict_valid` and `is_igmp` are 0, and `port_vec_out` equals `port_vec_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snoop_en | input | 1 | Global enable for IGMP trapping |
| in_valid | input | 1 | A header byte is present on `in_data` |
| in_sof | input | 1 | Current byte is the first byte of a frame |
| in_eof | input | 1 | Current byte is the last byte of a frame |
| in_data | input | 8 | Frame byte |
| port_vec_in | input | NPORTS | Forwarding vector from the lookup logic |
| verdict_valid | output | 1 | One-cycle pulse when a frame is decided |
| is_igmp | output | 1 | Latched verdict for the current frame |
| port_vec_out | output | NPORTS | Forwarding vector after the trap override |

## Verification
The bench targets the offset boundaries. It uses frames cut one byte before the protocol byte and frames whose last byte is the protocol byte. A design with an off-by-one protocol index would trap the first kind or miss the second. It exercises the length-field boundary at 1500 and 1501, and a damaged LLC byte. A design that skips the SNAP checks would trap non-IP SNAP traffic. It also sends tagged frames in both encapsulations, which catch a VLAN shift that is applied to only one path. Latching is checked across idle time, an enable change and the next start flag. A design that cleared the verdict too early or too late would misroute the frame's tail or the next frame's head.

// File: rtl/igmp_cls_pkg.sv
// Shared constants and types for the IGMP snooping classifier.
// Assumes byte 0 of each frame is the first destination-address byte.
package igmp_cls_pkg;

    localparam logic [15:0] ETYPE_IPV4  = 16'h0800;
    localparam logic [15:0] ETYPE_VLAN  = 16'h8100;
    localparam logic [15:0] LEN_LIMIT   = 16'd1500;
    localparam logic [7:0]  IP_PROTO_IGMP = 8'h02;
    localparam logic [3:0]  IP_VER4     = 4'h4;

    localparam int TYPE_OFS  = 12;   // first byte of type/length field
    localparam int L2_HDR    = 14;   // untagged Ethernet header length
    localparam int SNAP_LEN  = 8;    // LLC + SNAP header length
    localparam int VLAN_LEN  = 4;    // one 802.1Q tag
    localparam int PROTO_OFS = 9;    // protocol byte inside IPv4 header

    typedef enum logic [1:0] {
        ENC_NONE,
        ENC_ETH2,
        ENC_SNAP
    } encap_e;

    // Expected LLC/SNAP byte k for IP carried over SNAP.
    function automatic logic [7:0] snap_ref(input logic [2:0] k);
        case (k)
            3'd0, 3'd1: snap_ref = 8'hAA;
            3'd2:       snap_ref = 8'h03;
            3'd6:       snap_ref = 8'h08;
            default:    snap_ref = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/igmp_byte_index.sv
// Byte position tracker: gives the offset of the byte on the bus within
// its frame and whether the byte belongs to a frame at all.
// Assumes in_sof marks byte 0 and in_eof marks the final byte; the
// offset saturates at its maximum so long frames cannot wrap.
module igmp_byte_index #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    output logic [IDX_W-1:0] cur_idx,
    output logic             byte_live
);

    localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

    logic [IDX_W-1:0] nxt_q;
    logic             in_frame_q;

    // Offset of the present byte: zero on a start flag, else the running count.
    always_comb begin
        cur_idx   = in_sof ? '0 : nxt_q;
        byte_live = in_valid && (in_sof || in_frame_q);
    end

    // Advance the count per frame byte and track frame membership.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_q      <= '0;
            in_frame_q <= 1'b0;
        end else if (byte_live) begin
            nxt_q      <= (cur_idx == IDX_MAX) ? IDX_MAX : cur_idx + 1'b1;
            in_frame_q <= !in_eof;
        end
    end

    // Consecutive frame bytes must see consecutive offsets.
    assert_index_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_live && cur_idx != IDX_MAX) |=> (nxt_q == $past(cur_idx) + 1'b1));

endmodule

// File: rtl/igmp_hdr_match.sv
// Header matcher: follows the type/length field, an optional VLAN tag,
// the SNAP header and the IPv4 version and protocol bytes, and raises
// decide on the byte that settles the frame.
// Assumes cur_idx from igmp_byte_index; state is cleared on every start
// byte, so leftover state from the previous frame is never consulted
// (no check fires at offset 0).
module igmp_hdr_match
    import igmp_cls_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_live,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [7:0]       in_data,
    input  logic [IDX_W-1:0] cur_idx,
    output logic             decide,
    output logic             ipv4_igmp
);

    logic             tag_q;
    logic             decided_q;
    encap_e           enc_q;
    logic [7:0]       type_hi_q;

    logic [IDX_W-1:0] shift, hi_idx, lo_idx, snap_first, ip_base, proto_idx, snap_off;
    logic [15:0]      frame_type;
    logic             live, cap_hi, set_tag, set_enc, fail, proto_hit;
    encap_e           next_enc;

    // Offsets of the fields of interest, shifted by a seen VLAN tag.
    always_comb begin
        shift      = tag_q ? IDX_W'(VLAN_LEN) : '0;
        hi_idx     = IDX_W'(TYPE_OFS) + shift;
        lo_idx     = IDX_W'(TYPE_OFS + 1) + shift;
        snap_first = IDX_W'(L2_HDR) + shift;
        ip_base    = (enc_q == ENC_SNAP) ? IDX_W'(L2_HDR + SNAP_LEN) + shift
                                         : IDX_W'(L2_HDR) + shift;
        proto_idx  = ip_base + IDX_W'(PROTO_OFS);
        snap_off   = cur_idx - snap_first;
        frame_type = {type_hi_q, in_data};
    end

    // Per-byte field checks and the decision for this byte.
    always_comb begin
        live     = byte_live && (in_sof || !decided_q);
        cap_hi   = (enc_q == ENC_NONE) && (cur_idx == hi_idx);
        set_tag  = 1'b0;
        set_enc  = 1'b0;
        next_enc = ENC_NONE;
        fail     = 1'b0;
        if (enc_q == ENC_NONE && cur_idx == lo_idx && !in_sof) begin
            if (frame_type == ETYPE_VLAN && !tag_q) begin
                set_tag = 1'b1;
            end else if (frame_type == ETYPE_IPV4) begin
                set_enc  = 1'b1;
                next_enc = ENC_ETH2;
            end else if (frame_type <= LEN_LIMIT) begin
                set_enc  = 1'b1;
                next_enc = ENC_SNAP;
            end else begin
                fail = 1'b1;
            end
        end
        if (enc_q == ENC_SNAP && cur_idx >= snap_first &&
            cur_idx < snap_first + IDX_W'(SNAP_LEN) &&
            in_data != snap_ref(snap_off[2:0])) begin
            fail = 1'b1;
        end
        if (enc_q != ENC_NONE && cur_idx == ip_base && in_data[7:4] != IP_VER4) begin
            fail = 1'b1;
        end
        proto_hit = (enc_q != ENC_NONE) && (cur_idx == proto_idx) && !in_sof;
        decide    = live && (fail || proto_hit || in_eof);
        ipv4_igmp = proto_hit && !fail && (in_data == IP_PROTO_IGMP);
    end

    // Parse state: cleared on a start byte, updated on undecided frame bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q     <= 1'b0;
            enc_q     <= ENC_NONE;
            type_hi_q <= '0;
            decided_q <= 1'b0;
        end else if (byte_live && in_sof) begin
            tag_q     <= 1'b0;
            enc_q     <= ENC_NONE;
            decided_q <= decide;
        end else if (live) begin
            if (cap_hi)  type_hi_q <= in_data;
            if (set_tag) tag_q     <= 1'b1;
            if (set_enc) enc_q     <= next_enc;
            if (decide)  decided_q <= 1'b1;
        end
    end

    // A decided frame stays decided for the rest of its bytes.
    assert_single_verdict_R7: assert property (@(posedge clk) disable iff (!rst_n)
        decide |=> decided_q);

    // A SNAP match can only come from at or beyond the untagged SNAP protocol byte.
    assert_snap_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && ipv4_igmp && enc_q == ENC_SNAP) |->
            (cur_idx >= IDX_W'(L2_HDR + SNAP_LEN + PROTO_OFS)));

endmodule

// File: rtl/igmp_verdict.sv
// Verdict stage: registers the decision pulse, latches the gated IGMP
// flag until the next frame starts, and forces the forwarding vector to
// the processor port while the flag is set.
// Assumes decide is asserted at most once per frame.
module igmp_verdict #(
    parameter int NPORTS   = 5,
    parameter int CPU_PORT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              decide,
    input  logic              ipv4_igmp,
    input  logic              snoop_en,
    input  logic              byte_sof,
    input  logic [NPORTS-1:0] port_vec_in,
    output logic              verdict_valid,
    output logic              is_igmp,
    output logic [NPORTS-1:0] port_vec_out
);

    logic valid_q;
    logic hit_q;

    // Pulse on decision; latch gated match; clear when a new frame begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            hit_q   <= 1'b0;
        end else begin
            valid_q <= decide;
            if (decide)
                hit_q <= ipv4_igmp && snoop_en;
            else if (byte_sof)
                hit_q <= 1'b0;
        end
    end

    // Per-port override: processor port forced on, all others forced off.
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        if (p == CPU_PORT) begin : g_cpu
            assign port_vec_out[p] = port_vec_in[p] | hit_q;
        end else begin : g_other
            assign port_vec_out[p] = port_vec_in[p] & ~hit_q;
        end
    end

    assign verdict_valid = valid_q;
    assign is_igmp       = hit_q;

    // A latched trap must have been enabled when the frame was decided.
    assert_trap_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_q) |-> $past(snoop_en));

    // A latched trap only appears together with a verdict pulse.
    assert_trap_with_verdict_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_q) |-> valid_q);

endmodule

// File: rtl/igmp_snoop_classifier.sv
// Top of the IGMP snooping classifier: byte index, header matcher and
// verdict stage in series. Assumes one header byte per in_valid cycle.
module igmp_snoop_classifier #(
    parameter int NPORTS   = 5,
    parameter int CPU_PORT = 4,
    parameter int IDX_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snoop_en,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [7:0]        in_data,
    input  logic [NPORTS-1:0] port_vec_in,
    output logic              verdict_valid,
    output logic              is_igmp,
    output logic [NPORTS-1:0] port_vec_out
);

    logic [IDX_W-1:0] cur_idx;
    logic             byte_live;
    logic             decide;
    logic             ipv4_igmp;

    igmp_byte_index #(.IDX_W(IDX_W)) u_index (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .cur_idx   (cur_idx),
        .byte_live (byte_live)
    );

    igmp_hdr_match #(.IDX_W(IDX_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_live (byte_live),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .in_data   (in_data),
        .cur_idx   (cur_idx),
        .decide    (decide),
        .ipv4_igmp (ipv4_igmp)
    );

    igmp_verdict #(.NPORTS(NPORTS), .CPU_PORT(CPU_PORT)) u_verdict (
        .clk           (clk),
        .rst_n         (rst_n),
        .decide        (decide),
        .ipv4_igmp     (ipv4_igmp),
        .snoop_en      (snoop_en),
        .byte_sof      (byte_live && in_sof),
        .port_vec_in   (port_vec_in),
        .verdict_valid (verdict_valid),
        .is_igmp       (is_igmp),
        .port_vec_out  (port_vec_out)
    );

endmodule

// File: tb/igmp_snoop_classifier_tb.sv
module igmp_snoop_classifier_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] FWD_NORMAL = 5'b01111;
    localparam logic [4:0] FWD_CPU    = 5'b10000;

    typedef struct packed {
        logic        tag;
        logic        snap;
        logic        bad_llc;
        logic [15:0] typ;
        logic [3:0]  ver;
        logic [7:0]  proto;
        logic [6:0]  len;
        logic        en;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0,1'b0,1'b0,16'h0800,4'h4,8'h02,7'd60,1'b1,1'b1,4'd1},  // R1 plain IGMP
        '{1'b0,1'b0,1'b0,16'h0800,4'h4,8'h06,7'd60,1'b1,1'b0,4'd4},  // R4 TCP
        '{1'b0,1'b0,1'b0,16'h0800,4'h6,8'h02,7'd60,1'b1,1'b0,4'd4},  // R4 version 6
        '{1'b0,1'b0,1'b0,16'h86DD,4'h4,8'h02,7'd60,1'b1,1'b0,4'd4},  // R4 other type
        '{1'b0,1'b1,1'b0,16'h0040,4'h4,8'h02,7'd60,1'b1,1'b1,4'd2},  // R2 SNAP IGMP
        '{1'b0,1'b1,1'b1,16'h0040,4'h4,8'h02,7'd60,1'b1,1'b0,4'd5},  // R5 bad LLC
        '{1'b1,1'b0,1'b0,16'h0800,4'h4,8'h02,7'd64,1'b1,1'b1,4'd3},  // R3 tagged Eth II
        '{1'b1,1'b1,1'b0,16'h0040,4'h4,8'h02,7'd64,1'b1,1'b1,4'd3},  // R3 tagged SNAP
        '{1'b0,1'b0,1'b0,16'h0800,4'h4,8'h02,7'd60,1'b0,1'b0,4'd8},  // R8 disabled
        '{1'b0,1'b0,1'b0,16'h0800,4'h4,8'h02,7'd23,1'b1,1'b0,4'd6},  // R6 cut short
        '{1'b0,1'b0,1'b0,16'h0800,4'h4,8'h02,7'd24,1'b1,1'b1,4'd6},  // R6 ends on proto
        '{1'b0,1'b0,1'b0,16'h0600,4'h4,8'h02,7'd60,1'b1,1'b0,4'd5},  // R5 type 0x0600
        '{1'b0,1'b1,1'b0,16'h05DC,4'h4,8'h02,7'd60,1'b1,1'b1,4'd2},  // R2 length 1500
        '{1'b0,1'b1,1'b0,16'h0040,4'h4,8'h02,7'd31,1'b1,1'b0,4'd6},  // R6 SNAP cut short
        '{1'b1,1'b0,1'b0,16'h0800,4'h4,8'h02,7'd27,1'b1,1'b0,4'd6},  // R6 tagged cut short
        '{1'b0,1'b1,1'b0,16'h05DD,4'h4,8'h02,7'd60,1'b1,1'b0,4'd5}   // R5 length 1501
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       snoop_en = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic [4:0] port_vec_in = FWD_NORMAL;
    logic       verdict_valid;
    logic       is_igmp;
    logic [4:0] port_vec_out;

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    logic [7:0] fbuf [0:79];

    igmp_snoop_classifier u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .snoop_en      (snoop_en),
        .in_valid      (in_valid),
        .in_sof        (in_sof),
        .in_eof        (in_eof),
        .in_data       (in_data),
        .port_vec_in   (port_vec_in),
        .verdict_valid (verdict_valid),
        .is_igmp       (is_igmp),
        .port_vec_out  (port_vec_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count verdict pulses away from the active edge.
    always @(negedge clk) if (verdict_valid === 1'b1) vcount++;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic build(input vec_t v);
        int p;
        for (int i = 0; i < 80; i++) fbuf[i] = 8'h00;
        for (int i = 0; i < 12; i++) fbuf[i] = 8'h10 + 8'(i);
        p = 12;
        if (v.tag) begin
            fbuf[p] = 8'h81; fbuf[p+1] = 8'h00; fbuf[p+2] = 8'h00; fbuf[p+3] = 8'h05;
            p += 4;
        end
        fbuf[p] = v.typ[15:8]; fbuf[p+1] = v.typ[7:0];
        p += 2;
        if (v.snap) begin
            fbuf[p]   = 8'hAA; fbuf[p+1] = 8'hAA;
            fbuf[p+2] = v.bad_llc ? 8'h02 : 8'h03;
            fbuf[p+3] = 8'h00; fbuf[p+4] = 8'h00; fbuf[p+5] = 8'h00;
            fbuf[p+6] = 8'h08; fbuf[p+7] = 8'h00;
            p += 8;
        end
        fbuf[p]   = {v.ver, 4'h5};
        fbuf[p+3] = 8'h1C;
        fbuf[p+8] = 8'h01;
        fbuf[p+9] = v.proto;
    endtask

    task automatic send(input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = (i == len - 1);
            in_data  = fbuf[i];
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        idle(3);
        // R11: outputs idle during and after reset
        check(verdict_valid == 1'b0 && is_igmp == 1'b0, "R11", "reset flags",
              {verdict_valid, is_igmp}, 0);
        rst_n = 1'b1;
        idle(2);
        check(is_igmp == 1'b0 && verdict_valid == 1'b0, "R11", "post-reset flags",
              {verdict_valid, is_igmp}, 0);
        check(port_vec_out == FWD_NORMAL, "R11", "post-reset vector",
              port_vec_out, FWD_NORMAL);

        // Vector table walk
        for (int k = 0; k < NVEC; k++) begin
            build(VECS[k]);
            snoop_en = VECS[k].en;
            vcount = 0;
            send(int'(VECS[k].len));
            idle(3);
            check(vcount == 1, "R7", $sformatf("vec %0d verdict count", k), vcount, 1);
            check(is_igmp == VECS[k].exp, $sformatf("R%0d", VECS[k].req),
                  $sformatf("vec %0d verdict", k), is_igmp, VECS[k].exp);
            check(port_vec_out == (VECS[k].exp ? FWD_CPU : FWD_NORMAL), "R9",
                  $sformatf("vec %0d vector", k), port_vec_out,
                  VECS[k].exp ? FWD_CPU : FWD_NORMAL);
        end

        // R10 / R8: verdict held across idle and an enable change
        build(VECS[0]);
        snoop_en = 1'b1;
        send(60);
        idle(5);
        snoop_en = 1'b0;
        idle(2);
        check(is_igmp == 1'b1, "R8", "held after enable drop", is_igmp, 1);
        check(port_vec_out == FWD_CPU, "R10", "held vector", port_vec_out, FWD_CPU);

        // R7: stray bytes outside a frame give no verdict
        vcount = 0;
        @(negedge clk); in_valid = 1'b1; in_data = 8'h08;
        @(negedge clk); in_data = 8'h02;
        @(negedge clk); in_valid = 1'b0;
        idle(3);
        check(vcount == 0, "R7", "stray bytes", vcount, 0);
        check(is_igmp == 1'b1, "R10", "held over stray bytes", is_igmp, 1);

        // R10: cleared exactly after the next start byte
        @(negedge clk);
        in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b0; in_data = 8'h10;
        check(is_igmp == 1'b1, "R10", "still held before start edge", is_igmp, 1);
        @(negedge clk);
        check(is_igmp == 1'b0, "R10", "cleared after start byte", is_igmp, 0);
        in_sof = 1'b0; in_eof = 1'b1; in_data = 8'h11;
        @(negedge clk);
        in_valid = 1'b0; in_eof = 1'b0;
        idle(2);

        // R6 / R7: one-byte frame carrying start and end together
        vcount = 0;
        snoop_en = 1'b1;
        @(negedge clk);
        in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b1; in_data = 8'h02;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        check(verdict_valid == 1'b1, "R7", "one-byte frame pulse timing", verdict_valid, 1);
        idle(2);
        check(vcount == 1, "R7", "one-byte frame count", vcount, 1);
        check(is_igmp == 1'b0, "R6", "one-byte frame verdict", is_igmp, 0);

        // R7: back-to-back frames each get their own verdict
        vcount = 0;
        build(VECS[1]);
        send(30);
        build(VECS[0]);
        send(30);
        idle(3);
        check(vcount == 2, "R7", "back-to-back count", vcount, 2);
        check(is_igmp == 1'b1, "R1", "second frame verdict", is_igmp, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule